// File: doc/BRIEF.md
# Embedding Row Scatter-Accumulate Unit

The unit applies a stream of sparse updates to an embedding table held in memory. A command is configured by writing a 64-byte descriptor, one 32-bit word at a time, and is then started with a one-cycle pulse. For each index taken from the index stream, the unit finds the matching table row and fetches it one element at a time. It adds the next element of the update stream to each element and writes the result back to the same address. When the last write of the command has been acknowledged, it raises `done` for one cycle.

Indices are handled strictly one after another, and only one memory access is in flight at any time. An index that repeats an earlier one therefore always sees the row as already accumulated. Two checks guard the command:
- If the descriptor's command byte is wrong, or the table base is not 64-byte aligned, the command is refused before any memory access.
- If an index would place its row at or past the table bound, that row is skipped and its update elements are discarded. A sticky range flag is raised.

Top module: `emb_scatter_acc`

## Requirements
- R1: The descriptor is written as sixteen little-endian 32-bit words, where word n holds bytes 4n to 4n+3. The fields are:
  - byte 0x00: command byte, which must be 0xCA
  - byte 0x0C: index type tag
  - bytes 0x2C to 0x2F: table base
  - bytes 0x30 to 0x31: element count per row
  - bytes 0x32 to 0x33: low 16 bits of the row stride in bytes
  - bytes 0x34 to 0x35: number of indices
  - bytes 0x38 to 0x3B: table bound in bytes
  - bytes 0x3C to 0x3D: high 16 bits of the row stride
- R2: A start is refused in either of two cases: the command byte is not 0xCA, or bits [5:0] of the base are not zero. In that case `cfg_err` is set until the next start, `done` pulses, and no index, update or memory access takes place.
- R3: The row offset is index × stride, where the stride is the full 32 bits assembled from both halves. Element e of a row lives at byte address base + offset + 4·e, since elements are 32 bits wide.
- R4: Each element is read, the update element is added modulo 2^32, and the sum is written back to the same address.
- R5: Indices and update elements are consumed in arrival order. At most one read or write request is outstanding, so a repeated index accumulates on top of the earlier result.
- R6: If the 64-bit offset index × stride is greater than or equal to the bound, the row is neither read nor written. Its update elements are still consumed and discarded, and `err_range` is set. `err_range` stays set until the next start.
- R7: When the index type tag equals 0x01, only the low 16 bits of each index are used. Any other tag uses all 32 bits.
- R8: `done` is a single-cycle pulse that follows the acknowledgement of the command's last write. If the number of indices is zero, `done` pulses with no access at all.
- R9: After reset, `done`, `cfg_err`, `err_range`, `rd_req`, `wr_req`, `idx_ready` and `upd_ready` are all low.
- R10: `rd_req` and `rd_addr` hold steady until `rd_gnt` is seen. `wr_req`, `wr_addr` and `wr_data` hold steady until `wr_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Descriptor word write strobe |
| desc_widx | input | 4 | Descriptor word number (byte offset / 4) |
| desc_wdata | input | 32 | Descriptor word, little-endian |
| start | input | 1 | Start pulse, ignored while busy |
| idx_valid | input | 1 | Index stream valid |
| idx_ready | output | 1 | Index stream ready |
| idx_data | input | 32 | Row index |
| upd_valid | input | 1 | Update stream valid |
| upd_ready | output | 1 | Update stream ready |
| upd_data | input | 32 | Update element |
| rd_req | output | 1 | Memory read request |
| rd_gnt | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read byte address |
| rd_rvalid | input | 1 | Read data return strobe |
| rd_rdata | input | 32 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_ack | input | 1 | Write accepted |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| done | output | 1 | Command complete pulse |
| cfg_err | output | 1 | Descriptor refused (bad command byte or misaligned base) |
| err_range | output | 1 | At least one index was out of bound |

## Verification
The accumulation path is tried against a memory model whose grants and acknowledgements arrive only every other cycle. The update values sit near 2^32, so most sums wrap. Each command pattern separates one property from the others:
- A narrow-tag command carries an index with upper bits set, which shows whether only the low 16 bits are used.
- A command that repeats the same index shows whether each row update sees the previous result.
- A command mixing small and huge indices against a tight bound shows that skipped rows still consume their updates.
- A stride whose low half is zero shows whether the high half of the stride is used.

Directed runs cover refused descriptors, an empty index list, and the clearing of the range flag at the next start.

// File: rtl/esa_pkg.sv
package esa_pkg;

    localparam logic [7:0] CMD_BYTE   = 8'hCA;
    localparam logic [7:0] TAG_IDX16  = 8'h01;
    localparam int         ALIGN_BITS = 6;

    // descriptor word numbers (byte offset / 4)
    localparam logic [3:0] W_CMD    = 4'd0;
    localparam logic [3:0] W_TAG    = 4'd3;
    localparam logic [3:0] W_BASE   = 4'd11;
    localparam logic [3:0] W_CNT    = 4'd12;
    localparam logic [3:0] W_SEQ    = 4'd13;
    localparam logic [3:0] W_BOUND  = 4'd14;
    localparam logic [3:0] W_STRHI  = 4'd15;

    typedef struct packed {
        logic        idx16;
        logic [31:0] base;
        logic [15:0] elem_cnt;
        logic [31:0] stride;
        logic [15:0] seq_len;
        logic [31:0] bound;
    } esa_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE, S_IDX, S_CHK, S_RD, S_RWAIT, S_UPD, S_WR, S_DRAIN
    } esa_state_t;

    function automatic logic [31:0] narrow_index(input logic [31:0] raw, input logic use16);
        return use16 ? {16'h0, raw[15:0]} : raw;
    endfunction

endpackage

// File: rtl/esa_cfg_regs.sv
module esa_cfg_regs
    import esa_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           desc_we,
    input  logic [3:0]     desc_widx,
    input  logic [31:0]    desc_wdata,
    output esa_cfg_t       cfg,
    output logic           cfg_bad
);
    logic [7:0]  cmd_q;
    logic [15:0] stride_lo_q;
    logic [15:0] stride_hi_q;
    esa_cfg_t    c_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q       <= '0;
            stride_lo_q <= '0;
            stride_hi_q <= '0;
            c_q         <= '0;
        end else if (desc_we) begin
            case (desc_widx)
                W_CMD:   cmd_q <= desc_wdata[7:0];
                W_TAG:   c_q.idx16 <= (desc_wdata[7:0] == TAG_IDX16);
                W_BASE:  c_q.base <= desc_wdata;
                W_CNT: begin
                    c_q.elem_cnt <= desc_wdata[15:0];
                    stride_lo_q  <= desc_wdata[31:16];
                end
                W_SEQ:   c_q.seq_len <= desc_wdata[15:0];
                W_BOUND: c_q.bound <= desc_wdata;
                W_STRHI: stride_hi_q <= desc_wdata[15:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg        = c_q;
        cfg.stride = {stride_hi_q, stride_lo_q};
    end

    assign cfg_bad = (cmd_q != CMD_BYTE) || (c_q.base[ALIGN_BITS-1:0] != '0);

endmodule

// File: rtl/esa_row_addr.sv
module esa_row_addr #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [31:0]   stride,
    input  logic [31:0]   bound,
    input  logic [31:0]   index,
    input  logic [15:0]   elem,
    output logic          out_of_range,
    output logic [AW-1:0] elem_addr
);
    localparam int STEP = DW / 8;

    logic [63:0] offset;

    assign offset       = {32'h0, index} * {32'h0, stride};
    assign out_of_range = offset >= {32'h0, bound};
    assign elem_addr    = base + offset[AW-1:0] + AW'(elem) * AW'(STEP);

endmodule

// File: rtl/esa_seq_ctrl.sv
module esa_seq_ctrl
    import esa_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cfg_bad,
    input  logic          idx16,
    input  logic [15:0]   elem_cnt,
    input  logic [15:0]   seq_len,
    input  logic          out_of_range,
    input  logic          idx_valid,
    output logic          idx_ready,
    input  logic [31:0]   idx_data,
    input  logic          upd_valid,
    output logic          upd_ready,
    input  logic [DW-1:0] upd_data,
    output logic          rd_req,
    input  logic          rd_gnt,
    input  logic          rd_rvalid,
    input  logic [DW-1:0] rd_rdata,
    output logic          wr_req,
    input  logic          wr_ack,
    output logic [DW-1:0] wr_data,
    output logic [31:0]   cur_index,
    output logic [15:0]   cur_elem,
    output logic          done,
    output logic          cfg_err,
    output logic          err_range
);
    esa_state_t  state;
    logic        fin_q;
    logic [15:0] rows_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] sum_q;
    logic        last_row;
    logic        last_elem;
    esa_state_t  row_next;

    assign last_row  = (17'(rows_q) + 17'd1) == 17'(seq_len);
    assign last_elem = (17'(cur_elem) + 17'd1) == 17'(elem_cnt);
    assign row_next  = last_row ? S_IDLE : S_IDX;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            fin_q     <= 1'b0;
            rows_q    <= '0;
            cur_index <= '0;
            cur_elem  <= '0;
            rdata_q   <= '0;
            sum_q     <= '0;
            cfg_err   <= 1'b0;
            err_range <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (state)
                S_IDLE: if (start && !fin_q) begin
                    cfg_err   <= cfg_bad;
                    err_range <= 1'b0;
                    rows_q    <= '0;
                    if (cfg_bad || seq_len == '0) fin_q <= 1'b1;
                    else state <= S_IDX;
                end
                S_IDX: if (idx_valid) begin
                    cur_index <= narrow_index(idx_data, idx16);
                    cur_elem  <= '0;
                    state     <= S_CHK;
                end
                S_CHK: begin
                    if (out_of_range) err_range <= 1'b1;
                    if (elem_cnt == '0) begin
                        rows_q <= rows_q + 16'd1;
                        fin_q  <= last_row;
                        state  <= row_next;
                    end else begin
                        state <= out_of_range ? S_DRAIN : S_RD;
                    end
                end
                S_RD:    if (rd_gnt) state <= S_RWAIT;
                S_RWAIT: if (rd_rvalid) begin
                    rdata_q <= rd_rdata;
                    state   <= S_UPD;
                end
                S_UPD: if (upd_valid) begin
                    sum_q <= rdata_q + upd_data;
                    state <= S_WR;
                end
                S_WR, S_DRAIN: if ((state == S_WR) ? wr_ack : upd_valid) begin
                    cur_elem <= cur_elem + 16'd1;
                    if (last_elem) begin
                        rows_q <= rows_q + 16'd1;
                        fin_q  <= last_row;
                        state  <= row_next;
                    end else begin
                        state <= (state == S_WR) ? S_RD : S_DRAIN;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign idx_ready = (state == S_IDX);
    assign upd_ready = (state == S_UPD) || (state == S_DRAIN);
    assign rd_req    = (state == S_RD);
    assign wr_req    = (state == S_WR);
    assign wr_data   = sum_q;
    assign done      = fin_q;

endmodule

// File: rtl/emb_scatter_acc.sv
module emb_scatter_acc
    import esa_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          desc_we,
    input  logic [3:0]    desc_widx,
    input  logic [31:0]   desc_wdata,
    input  logic          start,
    input  logic          idx_valid,
    output logic          idx_ready,
    input  logic [31:0]   idx_data,
    input  logic          upd_valid,
    output logic          upd_ready,
    input  logic [DW-1:0] upd_data,
    output logic          rd_req,
    input  logic          rd_gnt,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_rvalid,
    input  logic [DW-1:0] rd_rdata,
    output logic          wr_req,
    input  logic          wr_ack,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          done,
    output logic          cfg_err,
    output logic          err_range
);
    esa_cfg_t    cfg;
    logic        cfg_bad;
    logic        oor;
    logic [31:0] cur_index;
    logic [15:0] cur_elem;
    logic [AW-1:0] elem_addr;

    esa_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .desc_we(desc_we), .desc_widx(desc_widx),
        .desc_wdata(desc_wdata), .cfg(cfg), .cfg_bad(cfg_bad)
    );

    esa_row_addr #(.AW(AW), .DW(DW)) u_addr (
        .base(AW'(cfg.base)), .stride(cfg.stride), .bound(cfg.bound),
        .index(cur_index), .elem(cur_elem),
        .out_of_range(oor), .elem_addr(elem_addr)
    );

    esa_seq_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cfg_bad(cfg_bad),
        .idx16(cfg.idx16), .elem_cnt(cfg.elem_cnt), .seq_len(cfg.seq_len),
        .out_of_range(oor),
        .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
        .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_data(upd_data),
        .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data),
        .cur_index(cur_index), .cur_elem(cur_elem),
        .done(done), .cfg_err(cfg_err), .err_range(err_range)
    );

    assign rd_addr = elem_addr;
    assign wr_addr = elem_addr;

endmodule

// File: rtl/esa_checker.sv
module esa_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_req,
    input logic          rd_gnt,
    input logic [AW-1:0] rd_addr,
    input logic          wr_req,
    input logic          wr_ack,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          idx_ready,
    input logic          upd_ready,
    input logic          done,
    input logic          cfg_err
);
    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_gnt |=> rd_req && $stable(rd_addr));

    // R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

    // R5
    one_access_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_req, wr_req, idx_ready, upd_ready}));

    // R5
    write_after_update_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_req) |-> $past(upd_ready));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    refused_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !rd_req && !wr_req && !idx_ready && !upd_ready);

    // R3
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> wr_addr[1:0] == 2'b00);

endmodule

bind emb_scatter_acc esa_checker #(.AW(AW), .DW(DW)) u_esa_chk (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_addr(rd_addr),
    .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
    .idx_ready(idx_ready), .upd_ready(upd_ready), .done(done), .cfg_err(cfg_err)
);

// File: tb/test_emb_scatter_acc.sv
module test_emb_scatter_acc;

    typedef struct packed {
        logic [31:0]       base;
        logic [15:0]       cnt;
        logic [31:0]       stride;
        logic [15:0]       seq;
        logic [31:0]       bound;
        logic [7:0]        tag;
        logic [3:0][31:0]  idx;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        // R7: narrow tag, index 0x10001 must act as 1
        '{32'h40,  16'd2, 32'd8,  16'd3, 32'h100, 8'h01, {32'd0, 32'd0, 32'd3, 32'h0001_0001}},
        // R5: repeated index accumulates
        '{32'h80,  16'd3, 32'd12, 16'd4, 32'h100, 8'h00, {32'd2, 32'd0, 32'd2, 32'd2}},
        // R6: skipped rows still consume updates
        '{32'h0,   16'd2, 32'd16, 16'd4, 32'h40,  8'h00, {32'd3, 32'h0001_0002, 32'd9, 32'd1}},
        // R3: stride wider than row; range flag cleared
        '{32'h100, 16'd1, 32'd16, 16'd2, 32'h1000,8'h00, {32'd0, 32'd0, 32'd5, 32'd0}},
        // R1: stride high half only
        '{32'h0,   16'd1, 32'h0001_0000, 16'd2, 32'h0001_0000, 8'h00, {32'd0, 32'd0, 32'd1, 32'd0}}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_we = 1'b0;
    logic [3:0]  desc_widx = '0;
    logic [31:0] desc_wdata = '0;
    logic        start = 1'b0;
    logic        idx_valid, idx_ready;
    logic [31:0] idx_data;
    logic        upd_valid, upd_ready;
    logic [31:0] upd_data;
    logic        rd_req, rd_gnt, rd_rvalid;
    logic [31:0] rd_addr, rd_rdata;
    logic        wr_req, wr_ack;
    logic [31:0] wr_addr, wr_data;
    logic        done, cfg_err, err_range;

    always #10 clk = ~clk;

    emb_scatter_acc i_emb_scatter_acc (
        .clk(clk), .rst(rst), .desc_we(desc_we), .desc_widx(desc_widx),
        .desc_wdata(desc_wdata), .start(start),
        .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
        .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_data(upd_data),
        .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_addr(rd_addr),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .cfg_err(cfg_err), .err_range(err_range)
    );

    // memory and stream models
    logic [31:0] mem [256];
    logic [31:0] refm [256];
    logic [31:0] iq [4];
    int          nidx = 0;
    int          ip = 0;
    int          up = 0;
    int          wr_cnt = 0;
    logic        tgl = 1'b0;
    logic        tb_clear = 1'b0;

    assign rd_gnt    = rd_req & tgl;
    assign wr_ack    = wr_req & tgl;
    assign idx_valid = ip < nidx;
    assign idx_data  = iq[ip % 4];
    assign upd_valid = 1'b1;
    assign upd_data  = 32'hFFFF_FFF0 + 32'(up);

    always @(posedge clk) begin
        tgl       <= ~tgl;
        rd_rvalid <= rd_req && rd_gnt;
        rd_rdata  <= mem[rd_addr[9:2]];
        if (tb_clear) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'(i * 3 + 5);
            ip     <= 0;
            up     <= 0;
            wr_cnt <= 0;
        end else begin
            if (wr_req && wr_ack) begin
                mem[wr_addr[9:2]] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (idx_valid && idx_ready) ip <= ip + 1;
            if (upd_valid && upd_ready) up <= up + 1;
        end
    end

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wdesc(input logic [3:0] w, input logic [31:0] d);
        @(negedge clk);
        desc_we = 1'b1; desc_widx = w; desc_wdata = d;
        @(negedge clk);
        desc_we = 1'b0;
    endtask

    task automatic load(input logic [7:0] cmd, input vec_t v);
        for (int w = 0; w < 16; w++) wdesc(4'(w), 32'h0);
        wdesc(4'd0,  {24'h0, cmd});
        wdesc(4'd3,  {24'h0, v.tag});
        wdesc(4'd11, v.base);
        wdesc(4'd12, {v.stride[15:0], v.cnt});
        wdesc(4'd13, {16'h0, v.seq});
        wdesc(4'd14, v.bound);
        wdesc(4'd15, {16'h0, v.stride[31:16]});
        for (int k = 0; k < 4; k++) iq[k] = v.idx[k];
        nidx = int'(v.seq);
        @(negedge clk); tb_clear = 1'b1;
        @(negedge clk); tb_clear = 1'b0;
        for (int i = 0; i < 256; i++) refm[i] = 32'(i * 3 + 5);
    endtask

    // returns 1 when done was seen, then checks that it lasted one cycle (R8)
    task automatic kick(output logic seen);
        seen = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int t = 0; t < 20000 && !seen; t++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        @(negedge clk);
        chk(!done, "R8 done single pulse", 64'(done), 0);
    endtask

    task automatic reference(input vec_t v, output int exp_wr, output logic exp_rng);
        int u = 0;
        exp_wr = 0; exp_rng = 1'b0;
        for (int k = 0; k < int'(v.seq); k++) begin
            logic [31:0] ix = (v.tag == 8'h01) ? {16'h0, v.idx[k][15:0]} : v.idx[k];
            logic [63:0] off = 64'(ix) * 64'(v.stride);
            if (off >= 64'(v.bound)) begin
                exp_rng = 1'b1;
                u += int'(v.cnt);
            end else begin
                for (int e = 0; e < int'(v.cnt); e++) begin
                    logic [31:0] a = v.base + off[31:0] + 32'(4 * e);
                    refm[a[9:2]] = refm[a[9:2]] + 32'hFFFF_FFF0 + 32'(u);
                    u++;
                    exp_wr++;
                end
            end
        end
    endtask

    initial begin
        logic seen;
        int   exp_wr;
        logic exp_rng;
        int   bad;
        vec_t v;

        repeat (3) @(negedge clk);
        // R9 reset state
        chk({done, cfg_err, err_range, rd_req, wr_req, idx_ready, upd_ready} == 7'b0,
            "R9 reset outputs", 64'({done, cfg_err, err_range, rd_req, wr_req, idx_ready, upd_ready}), 0);
        @(negedge clk); rst = 1'b0;

        for (int n = 0; n < NV; n++) begin
            v = VECS[n];
            load(8'hCA, v);
            reference(v, exp_wr, exp_rng);
            kick(seen);
            chk(seen, "R8 done seen", 64'(seen), 1);
            bad = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) bad++;
            // R4 R5 R3 R7 R1 memory image after accumulation
            chk(bad == 0, $sformatf("R4 memory image vector %0d", n), 64'(bad), 0);
            chk(wr_cnt == exp_wr, $sformatf("R5 write count vector %0d", n), 64'(wr_cnt), 64'(exp_wr));
            // R6 sticky flag, cleared at each start
            chk(err_range == exp_rng, $sformatf("R6 range flag vector %0d", n), 64'(err_range), 64'(exp_rng));
            chk(ip == int'(v.seq), $sformatf("R6 indices consumed vector %0d", n), 64'(ip), 64'(v.seq));
        end

        // R2 misaligned base
        v = VECS[0]; v.base = 32'h44;
        load(8'hCA, v);
        kick(seen);
        chk(seen && cfg_err, "R2 misaligned base refused", 64'({seen, cfg_err}), 3);
        chk(wr_cnt == 0 && ip == 0 && up == 0, "R2 no access on misaligned", 64'(wr_cnt + ip + up), 0);

        // R2 wrong command byte
        load(8'hCB, VECS[1]);
        kick(seen);
        chk(seen && cfg_err, "R2 wrong command refused", 64'({seen, cfg_err}), 3);
        chk(wr_cnt == 0 && ip == 0, "R2 no access on wrong command", 64'(wr_cnt + ip), 0);

        // R8 empty index list
        v = VECS[1]; v.seq = 16'd0;
        load(8'hCA, v);
        kick(seen);
        chk(seen && !cfg_err, "R8 empty list completes", 64'({seen, cfg_err}), 2);
        chk(wr_cnt == 0 && ip == 0, "R8 empty list no access", 64'(wr_cnt + ip), 0);

        // R2 a good start clears the refusal flag
        load(8'hCA, VECS[3]);
        reference(VECS[3], exp_wr, exp_rng);
        kick(seen);
        chk(!cfg_err && wr_cnt == exp_wr, "R2 flag cleared on good start", 64'({cfg_err, 8'(wr_cnt)}), 64'(exp_wr));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule